// File: doc/BRIEF.md
# Execution Trace Buffer Controller

This block watches the instruction-retire stream of a processor (a program counter, a length flag and an exception-entry flag on each retired instruction). It notices each time control flow leaves straight-line execution, such as a taken branch or an exception entry. For each such event it writes one two-word trace packet into an SRAM buffer: the first word is where execution came from and the second is where it went. A debug agent later reads the buffer back and rebuilds the path the program took.

The SRAM is also reachable from the processor's own bus. The SRAM is 64 bits wide, so a whole packet goes in as one write. A packet write always takes the SRAM in its cycle, and a processor access that arrives in that cycle waits for the next one. A small register file holds four things: a write position with a wrap marker, a run/stop control, a watermark setting, and the buffer's address in the memory map. With the watermark armed, tracing can stop by itself or ask the processor to halt once the buffer fills to a chosen point. Without it, the buffer wraps and older packets are overwritten.

Top module: `trace_buffer_ctrl`

## Requirements
- R1: Each packet fills one 8-byte slot at the write position. The word at byte offset +0 holds the source PC with bit 0 replaced by the run-start flag. The word at +4 holds the destination PC with bit 0 replaced by the exception-entry flag.
- R2: A retired instruction whose PC equals the previous PC plus 2 (previous instruction short) or plus 4 (previous instruction long), and which is not flagged as exception entry, produces no packet. Any other retire after the first one since reset produces a packet.
- R3: In a cycle where a packet is written, a processor request is not granted (`mem_gnt` low). It is granted in a later cycle once the SRAM is free.
- R4: Packets are recorded only while the run bit (control register at offset 0x4, bit 0) is 1. While it is 0, branches leave the position and the SRAM unchanged.
- R5: The first packet written after the run bit changes from 0 to 1 carries a 1 in bit 0 of its first word. Later packets carry 0 there.
- R6: The position register (offset 0x0) holds the slot pointer in bits [log2(size)-1:3] and the wrap flag in bit 2. Each packet advances the pointer by 8 bytes.
- R7: A packet written into the last slot of the buffer moves the pointer back to 0 and sets the wrap flag. The next packet overwrites slot 0.
- R8: Watermark register (offset 0x8): watermark in bits [log2(size)-1:3], auto-stop in bit 0. With auto-stop set, the packet written at the watermark slot is the last one, and the run bit reads 0 afterwards.
- R9: With auto-halt (watermark register bit 1) set, a packet written at the watermark slot raises `halt_req`. Tracing continues. `halt_req` stays high until software writes the control register.
- R10: After reset, the position, control and watermark registers read 0 and `halt_req` is low. Offset 0xC always reads the SRAM_BASE parameter and ignores writes.
- R11: A processor access addresses the buffer by 32-bit word index. Reads return data with `mem_rvalid` high in the cycle after the grant. Writes change only the addressed word.
- R12: A software write to the position register loads the pointer and the wrap flag from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | An instruction retired this cycle |
| trc_pc | input | 32 | PC of the retired instruction |
| trc_long | input | 1 | Retired instruction is 4 bytes long (else 2) |
| trc_exc | input | 1 | Retire is an exception entry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| mem_req | input | 1 | Processor SRAM request |
| mem_we | input | 1 | Processor request is a write |
| mem_addr | input | log2(BUF_BYTES)-2 | Word index into the buffer |
| mem_wdata | input | 32 | Processor write data |
| mem_gnt | output | 1 | Request accepted this cycle |
| mem_rdata | output | 32 | Processor read data |
| mem_rvalid | output | 1 | Read data valid |
| halt_req | output | 1 | Halt request to the processor |

## Verification
The bench runs a 64-byte buffer (eight slots) and steps it through a full wrap, an early auto-stop and an auto-halt, checking every slot's contents. The corner cases are these:
- A detector that mixes up which instruction's length decides sequence would log straight-line code.
- A start flag taken when a packet is captured rather than when it is written would mark two packets.
- A stop applied one cycle late would write a fourth packet past the watermark, and the bench sees that by reading back the stale word still in that slot.
- An arbiter that lets the processor win a tie shows up as a grant in the packet cycle.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  typedef enum logic [1:0] {
    OFS_POS  = 2'd0,
    OFS_CTRL = 2'd1,
    OFS_WMK  = 2'd2,
    OFS_LOC  = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic [31:0] dst;
    logic [31:0] src;
  } trc_pkt_t;
endpackage

// File: rtl/trc_flow_detect.sv
`timescale 1ns/1ps
module trc_flow_detect
  import trc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        valid,
  input  logic [31:0] pc,
  input  logic        is_long,
  input  logic        exc,
  output logic        pkt_vld,
  output trc_pkt_t    pkt
);
  logic [31:0] last_pc;
  logic        last_long;
  logic        have_last;
  logic [31:0] seq_pc;
  logic        jump;

  always_comb begin
    seq_pc = last_pc + (last_long ? 32'd4 : 32'd2);
    jump   = valid && have_last && ((pc != seq_pc) || exc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pc   <= '0;
      last_long <= 1'b0;
      have_last <= 1'b0;
      pkt_vld   <= 1'b0;
      pkt       <= '0;
    end else begin
      pkt_vld <= jump && run;
      if (jump && run) begin
        pkt.src <= last_pc;
        pkt.dst <= {pc[31:1], exc};
      end
      if (valid) begin
        last_pc   <= pc;
        last_long <= is_long;
        have_last <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trc_regs.sv
`timescale 1ns/1ps
module trc_regs
  import trc_pkg::*;
#(
  parameter int          PTR_W     = 10,
  parameter logic [31:0] SRAM_BASE = 32'h2000_0000,
  localparam int         PKT_W     = PTR_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             trace_wr,
  output logic [PKT_W-1:0] slot,
  output logic             wrap,
  output logic             run,
  output logic             start_pend,
  output logic [PKT_W-1:0] wmk,
  output logic             auto_stop,
  output logic             auto_halt,
  output logic             halt_req
);
  logic        at_wmk;
  logic [31:0] pos_val;
  logic [31:0] wmk_val;
  logic [31:0] rd_next;

  always_comb begin
    at_wmk  = trace_wr && (slot == wmk);
    pos_val = '0;
    pos_val[PTR_W-1:3] = slot;
    pos_val[2] = wrap;
    wmk_val = '0;
    wmk_val[PTR_W-1:3] = wmk;
    wmk_val[1] = auto_halt;
    wmk_val[0] = auto_stop;
    unique case (reg_ofs_e'(reg_sel))
      OFS_POS:  rd_next = pos_val;
      OFS_CTRL: rd_next = {31'd0, run};
      OFS_WMK:  rd_next = wmk_val;
      default:  rd_next = SRAM_BASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= '0;
      wrap       <= 1'b0;
      run        <= 1'b0;
      start_pend <= 1'b0;
      wmk        <= '0;
      auto_stop  <= 1'b0;
      auto_halt  <= 1'b0;
      halt_req   <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rdata <= rd_next;
      if (trace_wr) begin
        slot       <= slot + 1'b1;
        start_pend <= 1'b0;
        if (&slot) wrap <= 1'b1;
        if (at_wmk && auto_stop) run <= 1'b0;
        if (at_wmk && auto_halt) halt_req <= 1'b1;
      end
      if (reg_we) begin
        unique case (reg_ofs_e'(reg_sel))
          OFS_POS: begin
            slot <= reg_wdata[PTR_W-1:3];
            wrap <= reg_wdata[2];
          end
          OFS_CTRL: begin
            run      <= reg_wdata[0];
            halt_req <= 1'b0;
            if (reg_wdata[0] && !run) start_pend <= 1'b1;
          end
          OFS_WMK: begin
            wmk       <= reg_wdata[PTR_W-1:3];
            auto_halt <= reg_wdata[1];
            auto_stop <= reg_wdata[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trc_sram.sv
`timescale 1ns/1ps
module trc_sram #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);
  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) mem[addr][31:0]  <= wdata[31:0];
    if (we_hi) mem[addr][63:32] <= wdata[63:32];
    rdata <= mem[addr];
  end
endmodule

// File: rtl/trc_arb.sv
`timescale 1ns/1ps
module trc_arb #(
  parameter int  PKT_W   = 7,
  localparam int WORD_AW = PKT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trace_wr,
  input  logic [PKT_W-1:0]   trace_slot,
  input  logic [63:0]        trace_data,
  input  logic               mem_req,
  input  logic               mem_we,
  input  logic [WORD_AW-1:0] mem_addr,
  input  logic [31:0]        mem_wdata,
  output logic               mem_gnt,
  output logic               mem_rvalid,
  output logic               rd_lane,
  output logic [PKT_W-1:0]   ram_addr,
  output logic               ram_we_lo,
  output logic               ram_we_hi,
  output logic [63:0]        ram_wdata
);
  always_comb begin
    mem_gnt   = mem_req && !trace_wr;
    ram_addr  = mem_addr[WORD_AW-1:1];
    ram_we_lo = mem_gnt && mem_we && !mem_addr[0];
    ram_we_hi = mem_gnt && mem_we && mem_addr[0];
    ram_wdata = {mem_wdata, mem_wdata};
    if (trace_wr) begin
      ram_addr  = trace_slot;
      ram_we_lo = 1'b1;
      ram_we_hi = 1'b1;
      ram_wdata = trace_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      rd_lane    <= 1'b0;
    end else begin
      mem_rvalid <= mem_gnt && !mem_we;
      if (mem_gnt) rd_lane <= mem_addr[0];
    end
  end
endmodule

// File: rtl/trace_buffer_ctrl.sv
`timescale 1ns/1ps
module trace_buffer_ctrl
  import trc_pkg::*;
#(
  parameter int          BUF_BYTES = 1024,
  parameter logic [31:0] SRAM_BASE = 32'h2000_0000,
  localparam int         PTR_W     = $clog2(BUF_BYTES),
  localparam int         PKT_W     = PTR_W - 3,
  localparam int         WORD_AW   = PTR_W - 2,
  localparam int         SLOTS     = BUF_BYTES / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trc_valid,
  input  logic [31:0]        trc_pc,
  input  logic               trc_long,
  input  logic               trc_exc,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               mem_req,
  input  logic               mem_we,
  input  logic [WORD_AW-1:0] mem_addr,
  input  logic [31:0]        mem_wdata,
  output logic               mem_gnt,
  output logic [31:0]        mem_rdata,
  output logic               mem_rvalid,
  output logic               halt_req
);
  logic             pkt_vld;
  trc_pkt_t         pkt;
  logic             trace_wr;
  logic [PKT_W-1:0] slot;
  logic             wrap;
  logic             run;
  logic             start_pend;
  logic [PKT_W-1:0] wmk;
  logic             auto_stop;
  logic             auto_halt;
  logic [63:0]      pkt_word;
  logic [PKT_W-1:0] ram_addr;
  logic             ram_we_lo;
  logic             ram_we_hi;
  logic [63:0]      ram_wdata;
  logic [63:0]      ram_rdata;
  logic             rd_lane;
  logic [1:0]       unused_ofs;

  assign unused_ofs = reg_addr[1:0];
  assign trace_wr   = pkt_vld && run;
  assign pkt_word   = {pkt.dst, pkt.src[31:1], start_pend};
  assign mem_rdata  = rd_lane ? ram_rdata[63:32] : ram_rdata[31:0];

  trc_flow_detect u_detect (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .valid   (trc_valid),
    .pc      (trc_pc),
    .is_long (trc_long),
    .exc     (trc_exc),
    .pkt_vld (pkt_vld),
    .pkt     (pkt)
  );

  trc_regs #(.PTR_W(PTR_W), .SRAM_BASE(SRAM_BASE)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_sel    (reg_addr[3:2]),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trace_wr   (trace_wr),
    .slot       (slot),
    .wrap       (wrap),
    .run        (run),
    .start_pend (start_pend),
    .wmk        (wmk),
    .auto_stop  (auto_stop),
    .auto_halt  (auto_halt),
    .halt_req   (halt_req)
  );

  trc_arb #(.PKT_W(PKT_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .trace_wr   (trace_wr),
    .trace_slot (slot),
    .trace_data (pkt_word),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .rd_lane    (rd_lane),
    .ram_addr   (ram_addr),
    .ram_we_lo  (ram_we_lo),
    .ram_we_hi  (ram_we_hi),
    .ram_wdata  (ram_wdata)
  );

  trc_sram #(.DEPTH(SLOTS)) u_sram (
    .clk   (clk),
    .addr  (ram_addr),
    .we_lo (ram_we_lo),
    .we_hi (ram_we_hi),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );
endmodule

// File: rtl/trc_buf_checker.sv
`timescale 1ns/1ps
module trc_buf_checker #(
  parameter int PKT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_vld,
  input logic             run,
  input logic             mem_gnt,
  input logic             reg_we,
  input logic [3:0]       reg_addr,
  input logic [PKT_W-1:0] slot,
  input logic             wrap,
  input logic [PKT_W-1:0] wmk,
  input logic             auto_stop,
  input logic             auto_halt,
  input logic             halt_req
);
  logic wr_now, pos_wr, ctl_wr;
  assign wr_now = pkt_vld && run;
  assign pos_wr = reg_we && (reg_addr[3:2] == 2'd0);
  assign ctl_wr = reg_we && (reg_addr[3:2] == 2'd1);

  // R3: packet write owns the SRAM
  a_r3_trace_wins: assert property (@(posedge clk) disable iff (rst)
    wr_now |-> !mem_gnt);

  // R4: stopped tracing leaves the position alone
  a_r4_idle_ptr: assert property (@(posedge clk) disable iff (rst)
    (!run && !pos_wr) |=> $stable(slot));

  // R6: one slot per packet
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_now && !pos_wr) |=> (slot == $past(slot) + 1'b1));

  // R7: last slot wraps and marks it
  a_r7_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_now && !pos_wr && (&slot)) |=> (wrap && slot == '0));

  // R8: auto-stop at the watermark
  a_r8_auto_stop: assert property (@(posedge clk) disable iff (rst)
    (wr_now && auto_stop && slot == wmk && !ctl_wr) |=> !run);

  // R9: auto-halt at the watermark
  a_r9_auto_halt: assert property (@(posedge clk) disable iff (rst)
    (wr_now && auto_halt && slot == wmk && !ctl_wr) |=> halt_req);
endmodule

bind trace_buffer_ctrl trc_buf_checker #(.PKT_W(PKT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pkt_vld   (pkt_vld),
  .run       (run),
  .mem_gnt   (mem_gnt),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .slot      (slot),
  .wrap      (wrap),
  .wmk       (wmk),
  .auto_stop (auto_stop),
  .auto_halt (auto_halt),
  .halt_req  (halt_req)
);

// File: tb/tb_trace_buffer_ctrl.sv
`timescale 1ns/1ps
module tb_trace_buffer_ctrl;
  localparam int          BUF_BYTES = 64;
  localparam logic [31:0] BASE      = 32'h2000_0000;
  localparam int          WAW       = $clog2(BUF_BYTES) - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trc_valid = 1'b0, trc_long = 1'b0, trc_exc = 1'b0;
  logic [31:0] trc_pc = '0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req = 1'b0, mem_we = 1'b0;
  logic [WAW-1:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0, mem_rdata;
  logic mem_gnt, mem_rvalid, halt_req;

  int tests = 0, fails = 0;
  logic [31:0] last_pc = '0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  trace_buffer_ctrl #(.BUF_BYTES(BUF_BYTES), .SRAM_BASE(BASE)) dut (
    .clk(clk), .rst(rst),
    .trc_valid(trc_valid), .trc_pc(trc_pc), .trc_long(trc_long), .trc_exc(trc_exc),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .halt_req(halt_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic rd_mem(input int w, output logic [31:0] d);
    @(negedge clk); mem_req = 1'b1; mem_we = 1'b0; mem_addr = WAW'(w);
    #1;
    while (!mem_gnt) begin @(negedge clk); #1; end
    @(negedge clk); mem_req = 1'b0;
    chk("R11 rvalid", {31'd0, mem_rvalid}, 32'd1);
    d = mem_rdata;
  endtask

  task automatic wr_mem(input int w, input logic [31:0] d);
    @(negedge clk); mem_req = 1'b1; mem_we = 1'b1; mem_addr = WAW'(w); mem_wdata = d;
    #1;
    while (!mem_gnt) begin @(negedge clk); #1; end
    @(negedge clk); mem_req = 1'b0; mem_we = 1'b0;
  endtask

  task automatic retire(input logic [31:0] pc, input logic lng, input logic exc);
    @(negedge clk); trc_valid = 1'b1; trc_pc = pc; trc_long = lng; trc_exc = exc;
    @(negedge clk); trc_valid = 1'b0; trc_exc = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state and base register
    rd_reg(4'h0, v); chk("R10 position reset", v, 32'h0);
    rd_reg(4'h4, v); chk("R10 control reset", v, 32'h0);
    rd_reg(4'h8, v); chk("R10 watermark reset", v, 32'h0);
    rd_reg(4'hC, v); chk("R10 base", v, BASE);
    chk("R10 halt reset", {31'd0, halt_req}, 32'd0);
    wr_reg(4'hC, 32'h1234_5678);
    rd_reg(4'hC, v); chk("R10 base ignores write", v, BASE);

    // R11 processor access, per-word writes
    wr_mem(5, 32'hCAFE_F00D);
    wr_mem(4, 32'h1111_2222);
    rd_mem(5, v); chk("R11 read word5", v, 32'hCAFE_F00D);
    rd_mem(4, v); chk("R11 read word4", v, 32'h1111_2222);

    // R4 disabled: branch recorded nowhere
    retire(32'h100, 1'b0, 1'b0);
    retire(32'h300, 1'b0, 1'b0);
    rd_reg(4'h0, v); chk("R4 no packet while stopped", v, 32'h0);

    // R2 sequential runs of short and long instructions
    wr_reg(4'h4, 32'h1);
    retire(32'h302, 1'b1, 1'b0);
    retire(32'h306, 1'b0, 1'b0);
    rd_reg(4'h0, v); chk("R2 sequential silent", v, 32'h0);

    // R1 R5 R6 first branch after enable
    retire(32'h400, 1'b0, 1'b0);
    rd_reg(4'h0, v); chk("R6 pointer +8", v, 32'h8);
    rd_mem(0, v); chk("R5 start flag in source word", v, 32'h307);
    rd_mem(1, v); chk("R1 destination word", v, 32'h400);

    // R2 exception entry flagged, R5 start flag gone
    retire(32'h500, 1'b0, 1'b1);
    rd_mem(2, v); chk("R5 no start flag on second packet", v, 32'h400);
    rd_mem(3, v); chk("R1 exception flag in destination", v, 32'h501);
    last_pc = 32'h500;

    // R3 priority of a packet write over a pending read
    @(negedge clk); trc_valid = 1'b1; trc_pc = 32'h600;
    @(negedge clk); trc_valid = 1'b0; mem_req = 1'b1; mem_we = 1'b0; mem_addr = '0;
    #1; chk("R3 stalled during packet write", {31'd0, mem_gnt}, 32'd0);
    @(negedge clk); #1; chk("R3 granted afterwards", {31'd0, mem_gnt}, 32'd1);
    @(negedge clk); mem_req = 1'b0;
    chk("R3 rvalid after grant", {31'd0, mem_rvalid}, 32'd1);
    chk("R3 read data after stall", mem_rdata, 32'h307);
    rd_mem(4, v); chk("R1 third packet source", v, last_pc);
    last_pc = 32'h600;

    // R7 fill to the end and wrap
    for (int i = 0; i < 5; i++) begin
      retire(32'h1000 + 32'(i) * 32'h100, 1'b0, 1'b0);
    end
    rd_reg(4'h0, v); chk("R7 wrapped pointer and flag", v, 32'h4);
    rd_mem(6, v); chk("R1 slot3 source", v, 32'h600);
    rd_mem(15, v); chk("R1 last slot destination", v, 32'h1400);
    retire(32'h2000, 1'b0, 1'b0);
    rd_reg(4'h0, v); chk("R7 pointer after overwrite", v, 32'hC);
    rd_mem(0, v); chk("R7 slot0 overwritten source", v, 32'h1400);
    rd_mem(1, v); chk("R7 slot0 overwritten destination", v, 32'h2000);

    // R12 software sets position
    wr_reg(4'h0, 32'h0000_0014);
    rd_reg(4'h0, v); chk("R12 position load", v, 32'h14);
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, v); chk("R12 position clear", v, 32'h0);

    // R8 auto-stop at watermark slot 2
    wr_reg(4'h8, 32'h11);
    rd_reg(4'h8, v); chk("R8 watermark readback", v, 32'h11);
    for (int i = 0; i < 4; i++) begin
      retire(32'h3000 + 32'(i) * 32'h100, 1'b0, 1'b0);
    end
    rd_reg(4'h0, v); chk("R8 pointer stops past watermark", v, 32'h18);
    rd_reg(4'h4, v); chk("R8 run cleared", v, 32'h0);
    rd_mem(5, v); chk("R8 watermark slot written", v, 32'h3200);
    rd_mem(6, v); chk("R8 no packet past watermark", v, 32'h600);
    chk("R8 no halt without auto-halt", {31'd0, halt_req}, 32'd0);

    // R9 auto-halt at slot 1, R5 restart flag
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h8, 32'h0A);
    wr_reg(4'h4, 32'h1);
    retire(32'h4000, 1'b0, 1'b0);
    chk("R9 no halt before watermark", {31'd0, halt_req}, 32'd0);
    retire(32'h4100, 1'b0, 1'b0);
    chk("R9 halt at watermark", {31'd0, halt_req}, 32'd1);
    retire(32'h4200, 1'b0, 1'b0);
    rd_reg(4'h0, v); chk("R9 tracing continues", v, 32'h18);
    rd_mem(0, v); chk("R5 start flag after re-enable", v, 32'h3301);
    chk("R9 halt held", {31'd0, halt_req}, 32'd1);
    wr_reg(4'h4, 32'h1);
    chk("R9 halt cleared by control write", {31'd0, halt_req}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule